// File: doc/BRIEF.md
# System Clock Source Selector

This block chooses which of three free-running clocks drives the system clock: an internal oscillator, an external oscillator, or a clock multiplier. Software selects the source through a 2-bit field in an 8-bit control register on a simple register bus. Each source has an enable input. The external oscillator also has a settled flag that the block derives itself. In crystal mode the flag comes from a start-up counter clocked by the external oscillator. In RC or capacitor mode it comes from a short synchronizer. The multiplier reports its own ready signal.

A request for a source that is not enabled and settled stays pending. The block acts on it once the source becomes ready. A write of the reserved code is refused outright. The change itself is glitch-free. Each source has its own gate, with a two-flop synchronizer and a falling-edge enable flop. A gate may only open after every other gate has closed, so no high or low phase of the output is ever cut short. The external clock also reaches a separate peripheral clock output whenever it is enabled, whichever source is selected.

Top module: `sysclk_select`

## Requirements
- R1: After reset the control register reads 0x00, the internal oscillator drives `sys_clk`, `active_src` is 00 and `ext_valid` is low.
- R2: The control register is at bus address 0xA9 (parameter). Bits [1:0] hold the select code and bits [7:2] always read 0. A read of any other address returns 0x00, and a write to any other address is ignored.
- R3: The select codes are 00 for internal, 01 for external and 10 for multiplier. A write with code 11 is refused: the register and the active source stay unchanged.
- R4: The active source changes only when the requested source is ready. Internal is ready when `int_en` is high. External is ready when `ext_en` and `ext_valid` are both high. Multiplier is ready when `mul_en` and `mul_rdy` are both high. A request for a source that is not ready stays pending and takes effect once that source becomes ready.
- R5: `sys_clk` runs at the frequency of the active source, and `active_src` reports that source's code.
- R6: At most one source gate is open at a time. No high or low phase of `sys_clk` is shorter than the shortest half-period among the source clocks.
- R7: In crystal mode (`ext_xtal`=1), `ext_valid` rises only after `XTAL_START` external clock cycles with the enable synchronized, and never earlier. In RC mode it rises within 4 external cycles of enable. In either mode it falls within 4 external cycles after `ext_en` drops.
- R8: `periph_clk` carries `ext_clk` whenever `ext_en` is high, whatever the selected source, and is held low when `ext_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Register bus and control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register bus address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| int_clk | input | 1 | Internal oscillator clock |
| int_en | input | 1 | Internal oscillator enabled |
| ext_clk | input | 1 | External oscillator clock |
| ext_en | input | 1 | External oscillator enabled |
| ext_xtal | input | 1 | External mode: 1 crystal, 0 RC/capacitor |
| mul_clk | input | 1 | Clock multiplier output |
| mul_en | input | 1 | Clock multiplier enabled |
| mul_rdy | input | 1 | Clock multiplier locked |
| sys_clk | output | 1 | Selected system clock |
| periph_clk | output | 1 | External clock for peripherals |
| ext_valid | output | 1 | External oscillator settled |
| active_src | output | 2 | Code of the source whose gate is open |

## Verification
Assertions check on every cycle that at most one source gate is open. They also check that a request for a source that is not ready leaves the active source unchanged, that a refused code leaves the register as it was, and that `ext_valid` falls once the synchronized enable drops. The bench scenarios measure the actual `sys_clk` period after each switch and the shortest phase over the whole run. They also show the crystal start-up window, the held and later completed requests under random enable patterns, and the peripheral clock output running while another source is selected.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/1ps
package sysclk_pkg;
   localparam int NSRC = 3;
   typedef enum logic [1:0] {
      SRC_INT = 2'b00,
      SRC_EXT = 2'b01,
      SRC_MUL = 2'b10,
      SRC_RSV = 2'b11
   } src_e;
endpackage

// File: rtl/sysclk_gate_cell.sv
`timescale 1ns/1ps
// One clock gate: request synchronized on rising edges, opened/closed on falling edge
module sysclk_gate_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic on
);
   logic s1, s2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 1'b0;
         s2 <= 1'b0;
      end else begin
         s1 <= req;
         s2 <= s1;
      end
   end

   // falling-edge update: clock is low, so the gated output cannot be clipped
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) on <= 1'b0;
      else        on <= s2;
   end
endmodule

// File: rtl/sysclk_xtal_valid.sv
`timescale 1ns/1ps
module sysclk_xtal_valid #(
   parameter bit XTAL_EN    = 1'b1,
   parameter int XTAL_START = 64
) (
   input  logic ext_clk,
   input  logic rst_n,
   input  logic ext_en,
   input  logic xtal_mode,
   output logic valid
);
   localparam int CNT_W = $clog2(XTAL_START + 1);

   if (XTAL_START < 2) begin : g_bad_start
      $error("XTAL_START must be at least 2");
   end

   logic en_m, en_s;
   always_ff @(posedge ext_clk or negedge rst_n) begin
      if (!rst_n) begin
         en_m <= 1'b0;
         en_s <= 1'b0;
      end else begin
         en_m <= ext_en;
         en_s <= en_m;
      end
   end

   if (XTAL_EN) begin : g_counter
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge ext_clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt   <= '0;
            valid <= 1'b0;
         end else if (!en_s) begin
            cnt   <= '0;
            valid <= 1'b0;
         end else if (!xtal_mode) begin
            valid <= 1'b1;
         end else if (cnt != CNT_W'(XTAL_START - 1)) begin
            cnt <= cnt + 1'b1;
         end else begin
            valid <= 1'b1;
         end
      end
   end else begin : g_rc_only
      logic unused_mode;
      assign unused_mode = xtal_mode;
      always_ff @(posedge ext_clk or negedge rst_n) begin
         if (!rst_n) valid <= 1'b0;
         else        valid <= en_s;
      end
   end

   // R7: settled flag drops after the enable is removed
   a_r7_clears_on_disable: assert property (@(posedge ext_clk) disable iff (!rst_n)
      !en_s |=> !valid);
endmodule

// File: rtl/sysclk_regs.sv
`timescale 1ns/1ps
module sysclk_regs #(
   parameter int          AW       = 8,
   parameter int          DW       = 8,
   parameter logic [AW-1:0] SEL_ADDR = 8'hA9
) (
   input  logic          ctl_clk,
   input  logic          rst_n,
   input  logic [AW-1:0] reg_addr,
   input  logic          reg_we,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic [sysclk_pkg::NSRC-1:0] ok_raw,
   output logic [1:0]    tgt
);
   import sysclk_pkg::*;

   if (DW < 2) begin : g_bad_dw
      $error("register must hold the 2-bit select field");
   end

   logic [NSRC-1:0] ok_m, ok_s;
   logic [3:0]      ok_v;
   logic [1:0]      sel_q, tgt_q;
   logic            hit;
   logic            unused_hi;

   assign unused_hi = ^reg_wdata[DW-1:2];
   assign hit       = (reg_addr == SEL_ADDR);

   always_ff @(posedge ctl_clk or negedge rst_n) begin
      if (!rst_n) begin
         ok_m <= '0;
         ok_s <= '0;
      end else begin
         ok_m <= ok_raw;
         ok_s <= ok_m;
      end
   end

   always_comb begin
      ok_v = '0;
      ok_v[NSRC-1:0] = ok_s;
   end

   always_ff @(posedge ctl_clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= SRC_INT;
      end else if (reg_we && hit && reg_wdata[1:0] != SRC_RSV) begin
         sel_q <= reg_wdata[1:0];
      end
   end

   always_ff @(posedge ctl_clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q <= SRC_INT;
      end else if (sel_q != tgt_q && ok_v[sel_q]) begin
         tgt_q <= sel_q;
      end
   end

   assign tgt       = tgt_q;
   assign reg_rdata = hit ? {{(DW-2){1'b0}}, sel_q} : '0;

   a_r2_write_lands: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      (reg_we && hit && reg_wdata[1:0] != SRC_RSV) |=> (sel_q == $past(reg_wdata[1:0])));

   a_r3_reserved_refused: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      (reg_we && reg_wdata[1:0] == SRC_RSV) |=> $stable(sel_q));

   a_r4_wait_for_ready: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      (tgt_q != sel_q && !ok_v[sel_q]) |=> $stable(tgt_q));
endmodule

// File: rtl/sysclk_glitchfree.sv
`timescale 1ns/1ps
module sysclk_glitchfree #(
   parameter int N = 3
) (
   input  logic         rst_n,
   input  logic [N-1:0] clks,
   input  logic [1:0]   tgt,
   output logic [N-1:0] on,
   output logic         clk_out
);
   if (N < 2 || N > 4) begin : g_bad_n
      $error("selector supports 2 to 4 sources");
   end

   for (genvar i = 0; i < N; i++) begin : g_src
      localparam logic [N-1:0] OTHERS = ~(N'(1) << i);
      logic req;
      // open only once every other gate is closed
      assign req = (tgt == 2'(i)) && !(|(on & OTHERS));
      sysclk_gate_cell u_cell (
         .clk  (clks[i]),
         .rst_n(rst_n),
         .req  (req),
         .on   (on[i])
      );
   end

   assign clk_out = |(clks & on);
endmodule

// File: rtl/sysclk_select.sv
`timescale 1ns/1ps
module sysclk_select #(
   parameter logic [7:0] SEL_ADDR   = 8'hA9,
   parameter bit         XTAL_EN    = 1'b1,
   parameter int         XTAL_START = 64
) (
   input  logic       ctl_clk,
   input  logic       rst_n,
   input  logic [7:0] reg_addr,
   input  logic       reg_we,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       int_clk,
   input  logic       int_en,
   input  logic       ext_clk,
   input  logic       ext_en,
   input  logic       ext_xtal,
   input  logic       mul_clk,
   input  logic       mul_en,
   input  logic       mul_rdy,
   output logic       sys_clk,
   output logic       periph_clk,
   output logic       ext_valid,
   output logic [1:0] active_src
);
   import sysclk_pkg::*;

   logic [NSRC-1:0] ok_raw, gate_on, clks;
   logic [1:0]      tgt;
   logic            periph_on;

   assign ok_raw = {mul_en & mul_rdy, ext_en & ext_valid, int_en};
   assign clks   = {mul_clk, ext_clk, int_clk};

   sysclk_regs #(.AW(8), .DW(8), .SEL_ADDR(SEL_ADDR)) u_regs (
      .ctl_clk  (ctl_clk),
      .rst_n    (rst_n),
      .reg_addr (reg_addr),
      .reg_we   (reg_we),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .ok_raw   (ok_raw),
      .tgt      (tgt)
   );

   sysclk_xtal_valid #(.XTAL_EN(XTAL_EN), .XTAL_START(XTAL_START)) u_xtal (
      .ext_clk  (ext_clk),
      .rst_n    (rst_n),
      .ext_en   (ext_en),
      .xtal_mode(ext_xtal),
      .valid    (ext_valid)
   );

   sysclk_glitchfree #(.N(NSRC)) u_mux (
      .rst_n  (rst_n),
      .clks   (clks),
      .tgt    (tgt),
      .on     (gate_on),
      .clk_out(sys_clk)
   );

   sysclk_gate_cell u_periph (
      .clk  (ext_clk),
      .rst_n(rst_n),
      .req  (ext_en),
      .on   (periph_on)
   );
   assign periph_clk = ext_clk & periph_on;

   always_comb begin
      if (gate_on[1])      active_src = SRC_EXT;
      else if (gate_on[2]) active_src = SRC_MUL;
      else                 active_src = SRC_INT;
   end

   // R6: never two gates open together
   a_r6_single_gate: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      $onehot0(gate_on));
endmodule

// File: tb/sysclk_select_bench.sv
`timescale 1ns/1ps
module sysclk_select_bench;
   localparam int XS = 40;
   localparam real P_INT = 10.0, P_EXT = 14.0, P_MUL = 6.0;

   logic ctl_clk = 0, int_clk = 0, ext_clk = 0, mul_clk = 0;
   logic rst_n = 0;
   logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, reg_rdata;
   logic reg_we = 0;
   logic int_en = 1, ext_en = 0, ext_xtal = 1, mul_en = 0, mul_rdy = 0;
   logic sys_clk, periph_clk, ext_valid;
   logic [1:0] active_src;

   always #2.0 ctl_clk = ~ctl_clk;
   always #(P_INT/2) int_clk = ~int_clk;
   always #(P_EXT/2) ext_clk = ~ext_clk;
   always #(P_MUL/2) mul_clk = ~mul_clk;

   sysclk_select #(.XTAL_START(XS)) u_sysclk_select (
      .ctl_clk(ctl_clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_clk(int_clk), .int_en(int_en),
      .ext_clk(ext_clk), .ext_en(ext_en), .ext_xtal(ext_xtal), .mul_clk(mul_clk),
      .mul_en(mul_en), .mul_rdy(mul_rdy), .sys_clk(sys_clk), .periph_clk(periph_clk),
      .ext_valid(ext_valid), .active_src(active_src)
   );

   int n_run = 0, n_fail = 0;
   int pend = 0, cur = 0;

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   // shortest phase monitor (R6)
   bit  mon_en = 0;
   real last_t = 0.0, min_hi = 1.0e9, min_lo = 1.0e9;
   always @(sys_clk) begin
      if (mon_en) begin
         if (sys_clk === 1'b0 && ($realtime - last_t) < min_hi) min_hi = $realtime - last_t;
         if (sys_clk === 1'b1 && ($realtime - last_t) < min_lo) min_lo = $realtime - last_t;
      end
      last_t = $realtime;
   end

   int pcnt = 0;
   always @(posedge periph_clk) pcnt++;

   function automatic int period_ps(input int code);
      case (code)
         1: return 14000;
         2: return 6000;
         default: return 10000;
      endcase
   endfunction

   function automatic bit ready(input int code);
      case (code)
         0: return int_en;
         1: return ext_en;   // bench waits long enough for the settled flag
         2: return mul_en && mul_rdy;
         default: return 0;
      endcase
   endfunction

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge ctl_clk);
      reg_addr = a; reg_wdata = d; reg_we = 1;
      @(negedge ctl_clk);
      reg_we = 0; reg_addr = 8'hA9;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge ctl_clk);
      reg_addr = a;
      #0.5 d = reg_rdata;
      reg_addr = 8'hA9;
   endtask

   task automatic meas_sys(output int p);
      real t0;
      @(posedge sys_clk); t0 = $realtime;
      @(posedge sys_clk); p = $rtoi(($realtime - t0) * 1000.0 + 0.5);
   endtask

   task automatic meas_periph(output int p);
      real t0;
      @(posedge periph_clk); t0 = $realtime;
      @(posedge periph_clk); p = $rtoi(($realtime - t0) * 1000.0 + 0.5);
   endtask

   initial begin
      #400000;
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int p, c0;
      void'($urandom(32'd1234));
      #50 rst_n = 1;
      #150;
      mon_en = 1;
      // R1 reset state
      rd(8'hA9, d);
      check(d == 8'h00, "R1 reset register", d, 0);
      check(active_src == 2'd0, "R1 reset active source", active_src, 0);
      check(ext_valid == 1'b0, "R1 reset ext_valid", ext_valid, 0);
      meas_sys(p);
      check(p == 10000, "R1 reset sys_clk period ps", p, 10000);
      // R2 other address reads zero
      rd(8'h00, d);
      check(d == 8'h00, "R2 foreign address read", d, 0);
      // R4 request for multiplier while disabled: pending
      wr(8'hA9, 8'hFE);
      #400;
      rd(8'hA9, d);
      check(d == 8'h02, "R2 upper bits read zero", d, 2);
      check(active_src == 2'd0, "R4 held while not ready", active_src, 0);
      mul_en = 1; mul_rdy = 1;
      #400;
      check(active_src == 2'd2, "R4 pending request completes", active_src, 2);
      meas_sys(p);
      check(p == 6000, "R5 multiplier period ps", p, 6000);
      // R3 reserved code refused
      wr(8'hA9, 8'h03);
      #200;
      rd(8'hA9, d);
      check(d == 8'h02, "R3 reserved write register", d, 2);
      check(active_src == 2'd2, "R3 reserved write source", active_src, 2);
      // R2 write to foreign address ignored
      wr(8'hA8, 8'h00);
      #200;
      rd(8'hA9, d);
      check(d == 8'h02, "R2 foreign write ignored", d, 2);
      // R7 crystal start-up window
      ext_xtal = 1;
      @(posedge ext_clk); #1 ext_en = 1;
      repeat (XS - 2) @(posedge ext_clk);
      @(negedge ext_clk);
      check(ext_valid == 1'b0, "R7 no early valid", ext_valid, 0);
      repeat (8) @(posedge ext_clk);
      @(negedge ext_clk);
      check(ext_valid == 1'b1, "R7 valid after start-up", ext_valid, 1);
      // R8 peripheral clock while multiplier drives system
      meas_periph(p);
      check(p == 14000, "R8 periph period ps", p, 14000);
      // R5 switch to external
      wr(8'hA9, 8'h01);
      #400;
      check(active_src == 2'd1, "R5 external active", active_src, 1);
      meas_sys(p);
      check(p == 14000, "R5 external period ps", p, 14000);
      // R7 clear on disable, R8 periph stops
      @(posedge ext_clk); #1 ext_en = 0;
      repeat (4) @(posedge ext_clk);
      @(negedge ext_clk);
      check(ext_valid == 1'b0, "R7 valid clears", ext_valid, 0);
      #50 c0 = pcnt;
      #100;
      check(pcnt == c0, "R8 periph held low", pcnt - c0, 0);
      // R7 RC mode fast ready
      ext_xtal = 0;
      @(posedge ext_clk); #1 ext_en = 1;
      repeat (4) @(posedge ext_clk);
      @(negedge ext_clk);
      check(ext_valid == 1'b1, "R7 RC mode valid", ext_valid, 1);
      wr(8'hA9, 8'h00);
      #400;
      check(active_src == 2'd0, "R5 back to internal", active_src, 0);
      pend = 0; cur = 0;

      // random phase (R4, R5, R3, R2)
      for (int it = 0; it < 40; it++) begin
         int code;
         logic [7:0] a;
         @(negedge ctl_clk);
         int_en   = ($urandom % 4) != 0;
         ext_en   = $urandom % 2;
         ext_xtal = $urandom % 2;
         mul_en   = $urandom % 2;
         mul_rdy  = mul_en && (($urandom % 4) != 0);
         #1200;
         if (ready(pend)) cur = pend;
         code = $urandom % 4;
         a = (($urandom % 5) == 0) ? 8'h55 : 8'hA9;
         wr(a, {6'($urandom), 2'(code)});
         if (a == 8'hA9 && code != 3) pend = code;
         if (ready(pend)) cur = pend;
         #600;
         rd(8'hA9, d);
         check(d == 8'(pend), "R3 random register", d, pend);
         check(active_src == 2'(cur), "R4 random active source", active_src, cur);
         meas_sys(p);
         check(p == period_ps(cur), "R5 random period ps", p, period_ps(cur));
      end

      mon_en = 0;
      check(min_hi >= 2.95, "R6 min high ps", $rtoi(min_hi * 1000.0), 3000);
      check(min_lo >= 2.95, "R6 min low ps", $rtoi(min_lo * 1000.0), 3000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule